// File: doc/BRIEF.md
# Multi-lane block data serializer for SD/eMMC links

This block turns a packet of 32-bit words into the symbol stream that an SD or eMMC data bus carries during a block write. The payload enters on a stream input with valid, ready and last. It leaves as a sequence of lane symbols, where one symbol is the value of all eight data lanes for a single bit period. The bus runs 1, 4 or 8 lanes wide, in single or double data rate. The block frames each packet. It adds a start symbol, then the payload, then a 16-bit CRC for every active lane (and, in double data rate, one per lane and clock edge), then a stop symbol.

The front end pulls beats from the block with a ready handshake. A beat holds one or more consecutive symbols, set by configuration. This lets the same block feed a slow divided-clock pad driver or a wide fast one. The stream ready follows the actual symbol rate, so a word is taken only in the beat that sends its first bits. The enable input gates all activity. A busy output covers the whole frame. Configuration must stay constant while busy is high, and enable must stay high until busy falls.

Top module: `sd_blk_tx`

## Requirements
- R1: A frame begins in the first beat where `en` is high, a word is offered, the block is idle and the front end can take a beat. That beat's first symbol is the start symbol: 0 on every active lane and 1 on every other lane.
- R2: Lane count comes from `cfg_width`: 0 gives 1 lane, 1 gives 4 lanes, 2 gives 8 lanes, 3 gives 1 lane. Each word goes out most significant bits first. With L lanes, data symbol j of a word drives lane i (for i < L) with word bit 32-L-j*L+i, so in 4-lane mode the first symbol carries bits 31..28 on lanes 3..0.
- R3: In single data rate, 16 CRC symbols follow the data. Each active lane carries its own CRC over only the bits it sent, with polynomial 0x1021, a zero seed, and the most significant bit first.
- R4: In double data rate (`cfg_ddr`=1), data symbols with an even index in the data field feed edge-0 CRCs and odd ones feed edge-1 CRCs, separately for each lane. 32 CRC symbols follow the data, and CRC symbol k carries bit 15-k/2 of the edge (k mod 2) CRC of each lane.
- R5: A stop symbol of all ones follows the last CRC symbol. Lanes not in use stay 1 throughout the frame. `fe_sym` is all ones whenever `fe_valid` is low.
- R6: Each beat holds `cfg_nsym` symbols (0 or 1 means one symbol, 2 means two). Symbol 0 sits in bits 7:0 and goes first. A beat with `fe_valid` high and `fe_ready` low stays unchanged on the next cycle.
- R7: `s_ready` is high only in the cycle in which the offered word is consumed. No word is taken during the CRC or stop symbols. Input gaps and front-end stalls lose or repeat no data.
- R8: While `en` is low, `s_ready` stays low and no frame starts.
- R9: `busy` rises with the clock edge that loads the start beat. It stays high until the beat holding the stop symbol has been accepted, and falls on the following edge.
- R10: After reset, `fe_valid`, `busy` and `s_ready` are low and `fe_sym` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmit enable |
| cfg_width | input | 2 | Lane count select |
| cfg_ddr | input | 1 | Double data rate select |
| cfg_nsym | input | $clog2(NSLOT+1) | Symbols per beat |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word consumed |
| s_data | input | 32 | Stream word |
| s_last | input | 1 | Last word of packet |
| fe_ready | input | 1 | Front end takes the current beat |
| fe_valid | output | 1 | Beat valid |
| fe_sym | output | NSLOT*8 | Beat symbols, symbol 0 lowest |
| busy | output | 1 | Frame in progress |

## Verification
The bench covers every lane width, both data rates, both beat sizes and one- and three-word packets. It runs with random input gaps and random front-end stalls. Each frame is checked symbol by symbol against a model built from the requirements. A lane or bit-order slip shows up as scrambled data symbols. A CRC kept for the whole bus, or not split by edge, gives wrong CRC symbols. A ready that ignores beat alignment drops or repeats words under stalls. A busy that falls early shows up as a missing stop symbol when busy drops. Separate checks confirm that nothing moves while enable is low.

// File: rtl/sd_blk_tx_pkg.sv
package sd_blk_tx_pkg;
  localparam int WORD_W   = 32;
  localparam int LANE_MAX = 8;
  localparam int CRC_W    = 16;
  localparam int EDGE_N   = 2;
  localparam int CRC_N    = LANE_MAX * EDGE_N;
  localparam int CNT_W    = $clog2(WORD_W);
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_CRC, PH_STOP} phase_e;

  typedef struct packed {
    phase_e                         phase;
    logic [CNT_W-1:0]               cnt;
    logic [WORD_W-1:0]              sh;
    logic                           lastw;
    logic [CRC_N-1:0][CRC_W-1:0]    crc;
  } tx_state_t;

  typedef struct packed {
    tx_state_t           nxt;
    logic [LANE_MAX-1:0] sym;
    logic                took;
    logic                stall;
  } step_t;

  function automatic logic [CRC_W-1:0] crc_next(logic [CRC_W-1:0] c, logic b);
    return {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ b) ? CRC_POLY : '0);
  endfunction

  function automatic int lane_count(logic [1:0] wsel);
    return (wsel == 2'd1) ? 4 : (wsel == 2'd2) ? 8 : 1;
  endfunction

  // One bit period of the serializer.
  function automatic step_t tx_step(tx_state_t s, logic [1:0] wsel, logic ddr,
                                    logic can_start, logic wv,
                                    logic [WORD_W-1:0] wd, logic wl);
    step_t             r;
    int                nl;
    int                spw;
    int                e;
    int                bi;
    logic [WORD_W-1:0] src;
    logic              lw;
    nl  = lane_count(wsel);
    spw = WORD_W / nl;
    r   = '{nxt: s, sym: '1, took: 1'b0, stall: 1'b0};
    src = s.sh;
    lw  = s.lastw;
    case (s.phase)
      PH_IDLE: if (can_start) begin
        for (int i = 0; i < LANE_MAX; i++) if (i < nl) r.sym[i] = 1'b0;
        r.nxt.phase = PH_DATA;
        r.nxt.cnt   = '0;
        r.nxt.crc   = '0;
      end
      PH_DATA: begin
        if (s.cnt == '0) begin
          if (!wv) r.stall = 1'b1;
          else begin
            r.took = 1'b1;
            src    = wd;
            lw     = wl;
          end
        end
        if (!r.stall) begin
          e = ddr ? int'(s.cnt[0]) : 0;
          for (int i = 0; i < LANE_MAX; i++) begin
            if (i < nl) begin
              r.sym[i] = src[WORD_W - nl + i];
              r.nxt.crc[i*EDGE_N+e] = crc_next(s.crc[i*EDGE_N+e], src[WORD_W - nl + i]);
            end
          end
          r.nxt.sh    = src << nl;
          r.nxt.lastw = lw;
          if (int'(s.cnt) == spw - 1) begin
            r.nxt.cnt = '0;
            if (lw) r.nxt.phase = PH_CRC;
          end else r.nxt.cnt = s.cnt + 1'b1;
        end
      end
      PH_CRC: begin
        e  = ddr ? int'(s.cnt[0]) : 0;
        bi = ddr ? (CRC_W - 1 - int'(s.cnt) / 2) : (CRC_W - 1 - int'(s.cnt));
        for (int i = 0; i < LANE_MAX; i++)
          if (i < nl) r.sym[i] = s.crc[i*EDGE_N+e][bi];
        if (int'(s.cnt) == (ddr ? 2*CRC_W - 1 : CRC_W - 1)) begin
          r.nxt.phase = PH_STOP;
          r.nxt.cnt   = '0;
        end else r.nxt.cnt = s.cnt + 1'b1;
      end
      default: r.nxt.phase = PH_IDLE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sd_blk_tx_beat.sv
module sd_blk_tx_beat
  import sd_blk_tx_pkg::*;
#(
  parameter int NSLOT = 2,
  localparam int NS_W = $clog2(NSLOT + 1)
) (
  input  tx_state_t                    cur,
  input  logic [1:0]                   wsel,
  input  logic                         ddr,
  input  logic [NS_W-1:0]              nsym,
  input  logic                         en,
  input  logic                         s_valid,
  input  logic [WORD_W-1:0]            s_data,
  input  logic                         s_last,
  output tx_state_t                    nxt,
  output logic [NSLOT*LANE_MAX-1:0]    syms,
  output logic                         took,
  output logic                         stall
);
  tx_state_t         chain [NSLOT+1];
  step_t             res   [NSLOT];
  logic [NSLOT-1:0]  took_v;
  logic [NSLOT-1:0]  stall_v;

  assign chain[0] = cur;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic act;
    assign act = (k == 0) || (k < int'(nsym));
    always_comb res[k] = tx_step(chain[k], wsel, ddr, (k == 0) && en,
                                 s_valid, s_data, s_last);
    assign chain[k+1] = act ? res[k].nxt : chain[k];
    assign syms[k*LANE_MAX +: LANE_MAX] = act ? res[k].sym : '1;
    assign took_v[k]  = act & res[k].took;
    assign stall_v[k] = act & res[k].stall;
  end

  assign nxt   = chain[NSLOT];
  assign took  = |took_v;
  assign stall = |stall_v;
endmodule

// File: rtl/sd_blk_tx_out.sv
module sd_blk_tx_out #(
  parameter int SYM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [SYM_W-1:0] beat,
  input  logic             fe_ready,
  input  logic             active_d,
  output logic             fe_valid,
  output logic [SYM_W-1:0] fe_sym,
  output logic             busy
);
  logic valid_d;
  assign valid_d = fire | (fe_valid & ~fe_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      fe_valid <= 1'b0;
      fe_sym   <= '1;
      busy     <= 1'b0;
    end else begin
      fe_valid <= valid_d;
      busy     <= active_d | valid_d;
      if (fire) fe_sym <= beat;
      else if (fe_valid && fe_ready) fe_sym <= '1;
    end
  end

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
    fe_valid && !fe_ready |=> fe_valid && $stable(fe_sym)); // R6
  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (rst)
    !fe_valid |-> (fe_sym == '1)); // R5
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(fe_valid && fe_ready)); // R9
endmodule

// File: rtl/sd_blk_tx.sv
module sd_blk_tx
  import sd_blk_tx_pkg::*;
#(
  parameter int NSLOT = 2,
  localparam int NS_W = $clog2(NSLOT + 1),
  localparam int SYM_W = NSLOT * LANE_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_ddr,
  input  logic [NS_W-1:0]   cfg_nsym,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_last,
  input  logic              fe_ready,
  output logic              fe_valid,
  output logic [SYM_W-1:0]  fe_sym,
  output logic              busy
);
  tx_state_t        cur;
  tx_state_t        nxt;
  logic [SYM_W-1:0] beat;
  logic             took;
  logic             stall;
  logic             frame_go;
  logic             fire;
  logic             active_d;

  sd_blk_tx_beat #(.NSLOT(NSLOT)) u_beat (
    .cur(cur), .wsel(cfg_width), .ddr(cfg_ddr), .nsym(cfg_nsym), .en(en),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .nxt(nxt), .syms(beat), .took(took), .stall(stall)
  );

  assign frame_go = en && ((cur.phase != PH_IDLE) || s_valid);
  assign fire     = frame_go && !stall && (!fe_valid || fe_ready);
  assign s_ready  = fire && took;
  assign active_d = fire ? (nxt.phase != PH_IDLE) : (cur.phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) cur <= '{phase: PH_IDLE, default: '0};
    else if (fire) cur <= nxt;
  end

  sd_blk_tx_out #(.SYM_W(SYM_W)) u_out (
    .clk(clk), .rst(rst), .fire(fire), .beat(beat), .fe_ready(fe_ready),
    .active_d(active_d), .fe_valid(fe_valid), .fe_sym(fe_sym), .busy(busy)
  );

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> fe_valid && !fe_sym[0]); // R1
  AST_NO_TAKE_TAIL: assert property (@(posedge clk) disable iff (rst)
    (cur.phase == PH_CRC) || (cur.phase == PH_STOP) |-> !s_ready); // R7
  AST_EN_GATES: assert property (@(posedge clk) disable iff (rst)
    !en |-> !s_ready); // R8
endmodule

// File: tb/sd_blk_tx_test.sv
module sd_blk_tx_test;
  localparam int NSLOT = 2;

  logic        clk = 0;
  logic        rst = 1;
  logic        en = 0;
  logic [1:0]  cfg_width = 0;
  logic        cfg_ddr = 0;
  logic [1:0]  cfg_nsym = 1;
  logic        s_valid = 0;
  logic        s_ready;
  logic [31:0] s_data = 0;
  logic        s_last = 0;
  logic        fe_ready = 1;
  logic        fe_valid;
  logic [15:0] fe_sym;
  logic        busy;

  int checks = 0, errors = 0;
  int rmode = 0, gmode = 0, cycles = 0;
  logic [7:0] expv [256];
  logic [7:0] got  [256];
  int ngot = 0, nbeat = 0, cap_on = 0;

  always #4 clk = ~clk;

  sd_blk_tx #(.NSLOT(NSLOT)) uut (
    .clk(clk), .rst(rst), .en(en), .cfg_width(cfg_width), .cfg_ddr(cfg_ddr),
    .cfg_nsym(cfg_nsym), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .fe_ready(fe_ready), .fe_valid(fe_valid), .fe_sym(fe_sym),
    .busy(busy)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      checks = checks + 1;
      errors = errors + 1;
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (cap_on != 0 && fe_valid && fe_ready) begin
      nbeat = nbeat + 1;
      for (int s = 0; s < ((cfg_nsym == 2) ? 2 : 1); s++) begin
        if (ngot < 256) got[ngot] = fe_sym[s*8 +: 8];
        ngot = ngot + 1;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 fe_ready = (rmode != 0) ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expd);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, expd);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic check_region(input int lo, input int hi, input string req);
    int bad = -1;
    for (int i = lo; i < hi; i++) if (bad < 0 && got[i] !== expv[i]) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, $sformatf("%s symbol %0d", req, bad), int'(got[bad]), int'(expv[bad]));
  endtask

  task automatic run_frame(input int wsel, input int ddr, input int ns, input int nw);
    logic [31:0] words [3];
    logic [15:0] crcs [16];
    int nl, spw, idx, nd, nc, e, bi, gap;
    logic [7:0] sym;
    nl  = (wsel == 1) ? 4 : (wsel == 2) ? 8 : 1;
    spw = 32 / nl;
    for (int w = 0; w < nw; w++) words[w] = $urandom;
    for (int c = 0; c < 16; c++) crcs[c] = 16'h0;
    idx = 0;
    sym = 8'hFF;
    for (int i = 0; i < nl; i++) sym[i] = 1'b0;
    expv[idx++] = sym;
    for (int w = 0; w < nw; w++)
      for (int j = 0; j < spw; j++) begin
        sym = 8'hFF;
        e = (ddr != 0) ? (j % 2) : 0;
        for (int i = 0; i < nl; i++) begin
          sym[i] = words[w][32 - nl - j*nl + i];
          crcs[i*2+e] = crc_b(crcs[i*2+e], sym[i]);
        end
        expv[idx++] = sym;
      end
    nd = nw * spw;
    nc = (ddr != 0) ? 32 : 16;
    for (int k = 0; k < nc; k++) begin
      sym = 8'hFF;
      e  = (ddr != 0) ? (k % 2) : 0;
      bi = (ddr != 0) ? (15 - k/2) : (15 - k);
      for (int i = 0; i < nl; i++) sym[i] = crcs[i*2+e][bi];
      expv[idx++] = sym;
    end
    expv[idx++] = 8'hFF;

    @(posedge clk);
    #1;
    cfg_width = 2'(wsel); cfg_ddr = 1'(ddr); cfg_nsym = 2'(ns);
    ngot = 0; nbeat = 0; cap_on = 1; en = 1;
    for (int w = 0; w < nw; w++) begin
      gap = (gmode != 0) ? $urandom_range(0, 3) : 0;
      s_valid = 0;
      repeat (gap) @(posedge clk);
      #1;
      s_valid = 1; s_data = words[w]; s_last = (w == nw - 1);
      do @(negedge clk); while (!s_ready);
      @(posedge clk);
      #1 s_valid = 0; s_last = 0;
    end
    @(negedge clk);
    check(busy === 1'b1, "R9 busy during frame", int'(busy), 1);
    do @(negedge clk); while (busy);
    cap_on = 0;
    check(ngot == idx, "R9 all symbols out when busy falls", ngot, idx);
    check(nbeat * ((ns == 2) ? 2 : 1) == idx, "R6 beat count", nbeat, idx / ((ns == 2) ? 2 : 1));
    check(fe_valid === 1'b0 && fe_sym === 16'hFFFF, "R5 idle ones", int'(fe_sym), 16'hFFFF);
    if (ngot == idx) begin
      check_region(0, 1, "R1 start");
      check_region(1, 1 + nd, "R2 data");
      check_region(1 + nd, 1 + nd + nc, (ddr != 0) ? "R4 ddr crc" : "R3 crc");
      check_region(1 + nd + nc, idx, "R5 stop");
    end
    @(posedge clk);
    #1 en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(fe_valid === 1'b0, "R10 fe_valid", int'(fe_valid), 0);
    check(busy === 1'b0, "R10 busy", int'(busy), 0);
    check(s_ready === 1'b0, "R10 s_ready", int'(s_ready), 0);
    check(fe_sym === 16'hFFFF, "R10 fe_sym", int'(fe_sym), 16'hFFFF);

    // R8: word offered with enable low
    @(posedge clk);
    #1 s_valid = 1; s_data = 32'h1234_5678; s_last = 1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check(!s_ready && !fe_valid && !busy, "R8 enable low", int'({s_ready, fe_valid, busy}), 0);
    end
    @(posedge clk);
    #1 s_valid = 0; s_last = 0;

    for (int m = 0; m < 2; m++) begin
      rmode = m; gmode = m;
      for (int wsel = 0; wsel < 4; wsel++)
        for (int ddr = 0; ddr < 2; ddr++)
          for (int ns = 1; ns < 3; ns++) begin
            run_frame(wsel, ddr, ns, 1);
            run_frame(wsel, ddr, ns, 3);
          end
    end
    rmode = 0; gmode = 0;
    run_frame(0, 1, 0, 2);  // R6: nsym 0 acts as one symbol
    finish_run();
  end
endmodule